// File: doc/BRIEF.md
# Relative-Addressing Element Serializer

This block produces register-file access addresses for one SIMD lane that works on four wavefront elements over four pipelined cycles. An instruction supplies one base register index. In relative mode, each element adds its own signed offset, held in a per-lane address register, to that base. When every element ends up on the same register, a single wide access (four 32-bit words side by side) serves all four elements at once.

When the effective indices differ, the block does not need extra ports. It walks through the distinct indices one per cycle. Elements that share an index are served together in the same access. It raises a stall for every cycle except the last one. It pulses done in the cycle that serves the final elements, and accepts the next request in that same cycle.

The offsets are loaded beforehand by a separate load strobe that models the move-to-address-register operation.

Top module: `rel_elem_serializer`

## Requirements
- R1: While reset is held and after its release with no request, ready_o=1, stall_o=0, acc_vld_o=0, done_o=0 and elem_sel_o=0.
- R2: A request is accepted on a rising clock edge where req_i and ready_o are both high. Its first access is presented (acc_vld_o=1) in the cycle right after that edge.
- R3: With rel_en_i=0 at acceptance, the request produces exactly one access with acc_idx_o equal to base_idx_i, elem_sel_o=4'b1111, wide_o=1, done_o=1 and stall_o=0.
- R4: With rel_en_i=1, element e uses the effective index (base_idx_i + offset e) mod 128. Offset e is the signed 7-bit field ofs_i[7e+6:7e].
- R5: ofs_ld_i loads all offsets on a rising edge. A request accepted on that same edge still uses the previous offsets. Offsets persist until the next load, and reset clears them to zero.
- R6: When every effective index is equal, the request completes in a single wide access with no stall.
- R7: Accesses are issued one per cycle, one per distinct effective index, in the order of the lowest-numbered element still pending. Bit e of elem_sel_o (element e) is set for every pending element whose index equals acc_idx_o, and no element is served twice.
- R8: stall_o is high in every access cycle of a request except the last, so a request with D distinct indices stalls for D-1 cycles.
- R9: done_o is high exactly in the last access cycle of a request, and stall_o is low in that cycle.
- R10: ready_o is the inverse of stall_o. A req_i raised while stall_o is high is ignored and leaves no trace in the access sequence.
- R11: wide_o is high exactly when elem_sel_o is 4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ofs_ld_i | input | 1 | Load strobe for the per-element offset register |
| ofs_i | input | 28 | Four signed 7-bit offsets, element e in bits [7e+6:7e] |
| req_i | input | 1 | Access request for the current instruction |
| rel_en_i | input | 1 | Relative addressing enable for the request |
| base_idx_i | input | 7 | Base register index of the instruction |
| ready_o | output | 1 | A request can be accepted this cycle |
| acc_vld_o | output | 1 | An access is presented this cycle |
| acc_idx_o | output | 7 | Register index of the current access |
| elem_sel_o | output | 4 | Elements served by the current access, bit e for element e |
| wide_o | output | 1 | Current access serves all four elements |
| stall_o | output | 1 | More accesses of the current request follow; the pipeline must hold |
| done_o | output | 1 | Last access of the current request |

## Verification
The properties assume that req_i, rel_en_i, base_idx_i, ofs_ld_i and ofs_i are settled before each rising edge. They also assume that a request dropped while ready_o is low is expected to disappear rather than be queued. The stimulus changes every input only on the falling clock edge. It deliberately raises req_i during stalls and on the same edge as an offset load, so that the ignored-request and old-offset rules are exercised. The offset values are drawn mostly from a small set, so that partial index matches, full matches and wraparound past either end of the 128-entry register space all occur.

// File: rtl/rel_ser_pkg.sv
`timescale 1ns/1ps
package rel_ser_pkg;
  localparam int unsigned ELEM_DEF  = 4;
  localparam int unsigned IDX_W_DEF = 7;
  localparam int unsigned OFS_W_DEF = 7;
endpackage

// File: rtl/rel_ser_ofs_reg.sv
`timescale 1ns/1ps
module rel_ser_ofs_reg #(
  parameter int unsigned NUM_ELEM = 4,
  parameter int unsigned OFS_W    = 7
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ld_i,
  input  logic [NUM_ELEM*OFS_W-1:0] ofs_i,
  output logic [NUM_ELEM*OFS_W-1:0] ofs_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ofs_o <= '0;
    else if (ld_i) ofs_o <= ofs_i;
  end
endmodule

// File: rtl/rel_ser_eff_idx.sv
`timescale 1ns/1ps
module rel_ser_eff_idx #(
  parameter int unsigned NUM_ELEM = 4,
  parameter int unsigned IDX_W    = 7,
  parameter int unsigned OFS_W    = 7
) (
  input  logic                      rel_en_i,
  input  logic [IDX_W-1:0]          base_i,
  input  logic [NUM_ELEM*OFS_W-1:0] ofs_i,
  output logic [NUM_ELEM*IDX_W-1:0] eff_o
);
  for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem
    logic [OFS_W-1:0] ofs;
    logic [IDX_W-1:0] ext;
    assign ofs = ofs_i[e*OFS_W +: OFS_W];
    if (OFS_W == IDX_W) begin : g_same
      assign ext = ofs;
    end else begin : g_sext
      assign ext = {{(IDX_W-OFS_W){ofs[OFS_W-1]}}, ofs};
    end
    // modulo wrap falls out of the truncated add
    assign eff_o[e*IDX_W +: IDX_W] = rel_en_i ? base_i + ext : base_i;
  end
endmodule

// File: rtl/rel_ser_group.sv
`timescale 1ns/1ps
module rel_ser_group #(
  parameter int unsigned NUM_ELEM = 4,
  parameter int unsigned IDX_W    = 7
) (
  input  logic [NUM_ELEM-1:0]       pend_i,
  input  logic [NUM_ELEM*IDX_W-1:0] idx_i,
  output logic [IDX_W-1:0]          lead_o,
  output logic [NUM_ELEM-1:0]       sel_o,
  output logic [NUM_ELEM-1:0]       rest_o
);
  always_comb begin
    logic found;
    found  = 1'b0;
    lead_o = '0;
    for (int e = 0; e < NUM_ELEM; e++) begin
      if (pend_i[e] && !found) begin
        found  = 1'b1;
        lead_o = idx_i[e*IDX_W +: IDX_W];
      end
    end
  end

  for (genvar e = 0; e < NUM_ELEM; e++) begin : g_match
    assign sel_o[e] = pend_i[e] && (idx_i[e*IDX_W +: IDX_W] == lead_o);
  end

  assign rest_o = pend_i & ~sel_o;
endmodule

// File: rtl/rel_elem_serializer.sv
`timescale 1ns/1ps
module rel_elem_serializer
  import rel_ser_pkg::*;
#(
  parameter int unsigned NUM_ELEM = ELEM_DEF,
  parameter int unsigned IDX_W    = IDX_W_DEF,
  parameter int unsigned OFS_W    = OFS_W_DEF
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ofs_ld_i,
  input  logic [NUM_ELEM*OFS_W-1:0] ofs_i,
  input  logic                      req_i,
  input  logic                      rel_en_i,
  input  logic [IDX_W-1:0]          base_idx_i,
  output logic                      ready_o,
  output logic                      acc_vld_o,
  output logic [IDX_W-1:0]          acc_idx_o,
  output logic [NUM_ELEM-1:0]       elem_sel_o,
  output logic                      wide_o,
  output logic                      stall_o,
  output logic                      done_o
);
  localparam int unsigned FLAT_IDX = NUM_ELEM * IDX_W;
  localparam int unsigned FLAT_OFS = NUM_ELEM * OFS_W;

  logic [FLAT_OFS-1:0] ofs_q;
  logic [FLAT_IDX-1:0] eff_idx;
  logic [FLAT_IDX-1:0] idx_q;
  logic [NUM_ELEM-1:0] pend_q;
  logic [NUM_ELEM-1:0] sel;
  logic [NUM_ELEM-1:0] rest;
  logic [IDX_W-1:0]    lead;
  logic                accept;

  rel_ser_ofs_reg #(.NUM_ELEM(NUM_ELEM), .OFS_W(OFS_W)) u_ofs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (ofs_ld_i),
    .ofs_i  (ofs_i),
    .ofs_o  (ofs_q)
  );

  rel_ser_eff_idx #(.NUM_ELEM(NUM_ELEM), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_eff (
    .rel_en_i (rel_en_i),
    .base_i   (base_idx_i),
    .ofs_i    (ofs_q),
    .eff_o    (eff_idx)
  );

  rel_ser_group #(.NUM_ELEM(NUM_ELEM), .IDX_W(IDX_W)) u_grp (
    .pend_i (pend_q),
    .idx_i  (idx_q),
    .lead_o (lead),
    .sel_o  (sel),
    .rest_o (rest)
  );

  assign accept = req_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      idx_q  <= '0;
    end else if (accept) begin
      pend_q <= '1;
      idx_q  <= eff_idx;
    end else begin
      pend_q <= rest;
    end
  end

  assign acc_vld_o  = |pend_q;
  assign acc_idx_o  = lead;
  assign elem_sel_o = sel;
  assign wide_o     = &sel;
  assign stall_o    = |rest;
  assign done_o     = acc_vld_o && !stall_o;
  assign ready_o    = !stall_o;
endmodule

// File: rtl/rel_elem_serializer_chk.sv
`timescale 1ns/1ps
module rel_elem_serializer_chk #(
  parameter int unsigned NUM_ELEM = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                rel_en_i,
  input logic                ready_o,
  input logic                acc_vld_o,
  input logic [NUM_ELEM-1:0] elem_sel_o,
  input logic                stall_o,
  input logic                done_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_vld_o |-> (!stall_o && !done_o && elem_sel_o == '0)); // R1
  AST_ACCEPT_ISSUES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> acc_vld_o); // R2
  AST_FLAT_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && !rel_en_i) |=> (&elem_sel_o && done_o && !stall_o)); // R3
  AST_SEL_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_vld_o |-> (elem_sel_o != '0)); // R7
  AST_NO_REPEAT_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> ((elem_sel_o & $past(elem_sel_o)) == '0)); // R7
  AST_STALL_CONTINUES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> acc_vld_o); // R8
  AST_LAST_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_vld_o && !stall_o) |-> done_o); // R9
  AST_DONE_UNSTALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (acc_vld_o && !stall_o)); // R9
endmodule

bind rel_elem_serializer rel_elem_serializer_chk #(.NUM_ELEM(NUM_ELEM)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .rel_en_i   (rel_en_i),
  .ready_o    (ready_o),
  .acc_vld_o  (acc_vld_o),
  .elem_sel_o (elem_sel_o),
  .stall_o    (stall_o),
  .done_o     (done_o)
);

// File: tb/rel_elem_serializer_test.sv
`timescale 1ns/1ps
module rel_elem_serializer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ofs_ld_i = 1'b0;
  logic [27:0] ofs_i = '0;
  logic        req_i = 1'b0;
  logic        rel_en_i = 1'b0;
  logic [6:0]  base_idx_i = '0;
  logic        ready_o, acc_vld_o, wide_o, stall_o, done_o;
  logic [6:0]  acc_idx_o;
  logic [3:0]  elem_sel_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_ofs[4];
  int q_idx[$];
  int q_msk[$];

  always #10 clk_i = ~clk_i;

  rel_elem_serializer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ofs_ld_i(ofs_ld_i), .ofs_i(ofs_i),
    .req_i(req_i), .rel_en_i(rel_en_i), .base_idx_i(base_idx_i),
    .ready_o(ready_o), .acc_vld_o(acc_vld_o), .acc_idx_o(acc_idx_o),
    .elem_sel_o(elem_sel_o), .wide_o(wide_o), .stall_o(stall_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (time %0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // reference model: groups of distinct indices, lowest pending element first
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_idx.delete();
      q_msk.delete();
      for (int e = 0; e < 4; e++) exp_ofs[e] = 0;
    end else begin
      bit accept;
      accept = req_i && (q_idx.size() <= 1);
      if (q_idx.size() > 0) begin
        void'(q_idx.pop_front());
        void'(q_msk.pop_front());
      end
      if (accept) begin
        int eff[4];
        bit used[4];
        for (int e = 0; e < 4; e++) begin
          eff[e] = rel_en_i ? (((int'(base_idx_i) + exp_ofs[e]) % 128) + 128) % 128
                            : int'(base_idx_i);
          used[e] = 1'b0;
        end
        for (int e = 0; e < 4; e++) begin
          if (!used[e]) begin
            int m;
            m = 0;
            for (int j = e; j < 4; j++) begin
              if (!used[j] && eff[j] == eff[e]) begin
                m = m | (1 << j);
                used[j] = 1'b1;
              end
            end
            q_idx.push_back(eff[e]);
            q_msk.push_back(m);
          end
        end
      end
      if (ofs_ld_i) begin
        for (int e = 0; e < 4; e++) exp_ofs[e] = int'($signed(ofs_i[7*e +: 7]));
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      bit ev;
      bit es;
      ev = q_idx.size() > 0;
      es = q_idx.size() > 1;
      chk(acc_vld_o == ev, "R2 acc_vld", acc_vld_o, ev);
      chk(ready_o == !es, "R10 ready", ready_o, !es);
      chk(stall_o == es, "R8 stall", stall_o, es);
      chk(done_o == (ev && !es), "R9 done", done_o, ev && !es);
      if (ev) begin
        chk(acc_idx_o == q_idx[0], "R4 acc_idx", acc_idx_o, q_idx[0]);
        chk(elem_sel_o == q_msk[0], "R7 elem_sel", elem_sel_o, q_msk[0]);
        chk(wide_o == (q_msk[0] == 15), "R11 wide", wide_o, q_msk[0] == 15);
      end else begin
        chk(elem_sel_o == 0, "R1 idle sel", elem_sel_o, 0);
      end
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  task automatic load_ofs(input int a, input int b, input int c, input int d);
    @(negedge clk_i);
    ofs_ld_i = 1'b1;
    ofs_i = {7'(d), 7'(c), 7'(b), 7'(a)};
    @(negedge clk_i);
    ofs_ld_i = 1'b0;
  endtask

  // drives one request cycle; returns at the falling edge of the first access cycle
  task automatic issue(input bit rel, input int base);
    @(negedge clk_i);
    req_i = 1'b1;
    rel_en_i = rel;
    base_idx_i = 7'(base);
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  function automatic int pick_ofs();
    int r;
    r = int'($urandom_range(0, 7));
    case (r)
      0: return 0;
      1: return 1;
      2: return -1;
      3: return 63;
      4: return -64;
      default: return int'($urandom_range(0, 127)) - 64;
    endcase
  endfunction

  initial begin
    // R1 reset state
    idle(2);
    chk(ready_o && !stall_o && !acc_vld_o && !done_o, "R1 in reset", {ready_o, stall_o, acc_vld_o, done_o}, 4'b1000);
    rst_ni = 1'b1;
    idle(2);
    chk(ready_o && !stall_o && !acc_vld_o && !done_o && elem_sel_o == 0, "R1 after reset",
        {ready_o, stall_o, acc_vld_o, done_o}, 4'b1000);

    // R3 relative mode off, even with offsets loaded
    load_ofs(5, -3, 7, 20);
    issue(1'b0, 42);
    chk(acc_vld_o && acc_idx_o == 42 && elem_sel_o == 4'hF && wide_o && done_o && !stall_o,
        "R3 flat access", acc_idx_o, 42);
    idle(3);

    // R6 equal offsets give one wide access
    load_ofs(9, 9, 9, 9);
    issue(1'b1, 10);
    chk(acc_idx_o == 19 && wide_o && done_o && !stall_o, "R6 uniform wide", acc_idx_o, 19);
    idle(2);

    // R7/R8 all distinct: four accesses, three stall cycles
    load_ofs(0, 1, 2, 3);
    issue(1'b1, 100);
    chk(acc_idx_o == 100 && elem_sel_o == 4'b0001 && stall_o, "R7 first of four", acc_idx_o, 100);
    idle(1);
    chk(acc_idx_o == 101 && elem_sel_o == 4'b0010 && stall_o, "R8 second of four", acc_idx_o, 101);
    idle(2);
    chk(acc_idx_o == 103 && elem_sel_o == 4'b1000 && done_o && !stall_o, "R9 last of four", acc_idx_o, 103);
    idle(2);

    // R7 pairs sharing an index are grouped
    load_ofs(4, -2, 4, -2);
    issue(1'b1, 50);
    chk(acc_idx_o == 54 && elem_sel_o == 4'b0101 && stall_o, "R7 pair group A", elem_sel_o, 5);
    idle(1);
    chk(acc_idx_o == 48 && elem_sel_o == 4'b1010 && done_o, "R7 pair group B", elem_sel_o, 10);
    idle(2);

    // R4 wraparound at both ends
    load_ofs(10, -5, 10, 10);
    issue(1'b1, 120);
    chk(acc_idx_o == 2 && elem_sel_o == 4'b1101, "R4 wrap high", acc_idx_o, 2);
    idle(1);
    chk(acc_idx_o == 115 && elem_sel_o == 4'b0010 && done_o, "R4 second group", acc_idx_o, 115);
    idle(2);
    load_ofs(-5, -5, -5, -5);
    issue(1'b1, 3);
    chk(acc_idx_o == 126 && wide_o, "R4 wrap low", acc_idx_o, 126);
    idle(2);

    // R5 load on same edge as request: old offsets used, new ones next time
    load_ofs(1, 1, 1, 1);
    @(negedge clk_i);
    ofs_ld_i = 1'b1;
    ofs_i = {7'(0), 7'(0), 7'(0), 7'(30)};
    req_i = 1'b1;
    rel_en_i = 1'b1;
    base_idx_i = 7'd60;
    @(negedge clk_i);
    ofs_ld_i = 1'b0;
    req_i = 1'b0;
    chk(acc_idx_o == 61 && wide_o, "R5 old offsets on load edge", acc_idx_o, 61);
    idle(1);
    issue(1'b1, 60);
    chk(acc_idx_o == 90 && elem_sel_o == 4'b0001, "R5 new offsets persist", acc_idx_o, 90);
    idle(3);

    // R10 request during stall is ignored
    load_ofs(0, 1, 2, 3);
    issue(1'b1, 20);
    req_i = 1'b1;
    rel_en_i = 1'b0;
    base_idx_i = 7'd77;
    @(negedge clk_i);
    chk(!ready_o && acc_idx_o == 21, "R10 held off while stalled", ready_o, 0);
    @(negedge clk_i);
    req_i = 1'b0;
    @(negedge clk_i);
    chk(acc_idx_o == 23 && done_o, "R10 sequence unchanged", acc_idx_o, 23);
    idle(1);
    chk(!acc_vld_o, "R10 no extra access", acc_vld_o, 0);

    // R2 back-to-back uniform requests, one per cycle
    load_ofs(0, 0, 0, 0);
    @(negedge clk_i);
    req_i = 1'b1;
    rel_en_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      base_idx_i = 7'(i * 11);
      @(negedge clk_i);
      chk(acc_vld_o && acc_idx_o == 7'(i * 11) && done_o, "R2 back-to-back", acc_idx_o, i * 11);
    end
    req_i = 1'b0;
    idle(2);

    // random mix, checked every cycle by the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk_i);
      ofs_ld_i = ($urandom_range(0, 3) == 0);
      ofs_i = {7'(pick_ofs()), 7'(pick_ofs()), 7'(pick_ofs()), 7'(pick_ofs())};
      req_i = ($urandom_range(0, 2) != 0);
      rel_en_i = ($urandom_range(0, 4) != 0);
      base_idx_i = 7'($urandom_range(0, 127));
    end
    @(negedge clk_i);
    ofs_ld_i = 1'b0;
    req_i = 1'b0;
    idle(6);
    finish_run();
  end
endmodule